// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Sequencer

This block sits between a clocked host and a 512K x 16 pseudo-static RAM that has only asynchronous strobes. The host issues one word request at a time over a valid/ready channel. A request carries a direction bit, a 19-bit word address, 16 bits of write data and two active-high byte enables. The sequencer turns each request into a fixed strobe sequence whose phase lengths are parameters counted in clock cycles. Read data comes back on a separate one-cycle strobe. The memory data bus is presented as separate drive-value, drive-enable and sampled-input signals, so a pad ring or a tri-state buffer can be placed outside the block.

Every access has four phases: address settle, strobe, hold and recovery. In the address-settle phase the address is on the bus and the chip is still deselected. The strobe phase selects the chip and the chosen lanes. The hold phase deselects the chip while write data stays on the bus. The recovery phase leaves the bus released and the part in standby. Because the chip select opens the read, reads are controlled by chip enable. A write opens and closes on the overlap of all enabling strobes, and every one of them closes together.

Back-pressure rules: the host raises valid with a stable payload and keeps both unchanged until a clock edge at which ready is high. That edge accepts the request. Ready then stays low for the whole access, including recovery. When valid is low, the block does nothing.

Top module: `psram_seq`

## Requirements
- R1: After reset, the memory is in standby: active-low select high, active-high select low, output enable high, write strobe high, both lane strobes high, data drive off, ready high and response valid low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is then low for SETUP_CYC + (RD_CYC or WR_CYC) + HOLD_CYC + RECOV_CYC cycles. Valid asserted while ready is low is not taken until ready returns.
- R3: For SETUP_CYC cycles after acceptance, the request address is on the address bus while the chip stays deselected. The address does not change while the chip is selected.
- R4: A read selects the chip (active-low select low, active-high select high) with output enable low and write strobe high for exactly RD_CYC cycles.
- R5: A write selects the chip with the write strobe low and output enable high for exactly WR_CYC cycles. The write strobe is low only while the chip is selected.
- R6: During the strobe phase, the lower lane strobe (data bits 7..0) is low exactly when byte-enable bit 0 is set, and the upper lane strobe (bits 15..8) is low exactly when bit 1 is set. A write with both bits clear strobes no lane and leaves the memory unchanged.
- R7: The data bus is driven only during the settle, strobe and hold phases of a write, and it carries the request's write data. It is never driven while output enable is low, and it is released at least one cycle before output enable falls.
- R8: A write ends with the select, write strobe and lane strobes all going inactive on the same edge. Write data stays driven and unchanged for HOLD_CYC cycles after that edge.
- R9: A read's data is sampled on the edge that ends its strobe phase. Response valid is high for exactly the next cycle, and any lane the request did not enable reads as zero.
- R10: Outside the strobe phase, the chip is deselected and both lane strobes, output enable and the write strobe are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
The bench holds valid high straight from a write into the next read. A design that released the bus late, or raised output enable too early, would show drive-enable and output enable active together in the same cycle. Single-lane writes and single-lane reads are mixed at the same address, and the device model returns junk on lanes that are not strobed. Wrong lane decode would therefore corrupt the neighbouring byte or leak junk into the response. The bench also covers a write with no lanes enabled, which must leave the word unchanged, and the top address. Every phase boundary is compared against the reference count each cycle, so an off-by-one in any phase length, or data dropped at the write-terminating edge, fails at the cycle where it happens.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_t;
endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
  import psram_seq_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int RD_CYC    = 4,
  parameter int WR_CYC    = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 2,
  parameter int TMR_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_write,
  input  logic             expired,
  output phase_t           phase,
  output logic             load,
  output logic [TMR_W-1:0] load_val
);
  localparam logic [TMR_W-1:0] LV_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LV_RD    = TMR_W'(RD_CYC - 1);
  localparam logic [TMR_W-1:0] LV_WR    = TMR_W'(WR_CYC - 1);
  localparam logic [TMR_W-1:0] LV_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] LV_RECOV = TMR_W'(RECOV_CYC - 1);

  phase_t nxt;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        nxt = PH_SETUP; load = 1'b1; load_val = LV_SETUP;
      end
      PH_SETUP: if (expired) begin
        nxt = PH_STROBE; load = 1'b1; load_val = is_write ? LV_WR : LV_RD;
      end
      PH_STROBE: if (expired) begin
        nxt = PH_HOLD; load = 1'b1; load_val = LV_HOLD;
      end
      PH_HOLD: if (expired) begin
        nxt = PH_RECOV; load = 1'b1; load_val = LV_RECOV;
      end
      PH_RECOV: if (expired) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end
endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              sel,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] rd_bus,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] rd_masked
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i]            = ~(sel & be[i]);
    assign rd_masked[8*i +: 8]  = be[i] ? rd_bus[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int RD_CYC    = 4,
  parameter int WR_CYC    = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 2,
  localparam int LANES    = DATA_W / 8,
  localparam int MAX_A    = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC,
  localparam int MAX_B    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC,
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int MAX_CYC  = (MAX_C > RECOV_CYC) ? MAX_C : RECOV_CYC,
  localparam int TMR_W    = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  phase_t             phase;
  logic               load, expired, accept, sel;
  logic [TMR_W-1:0]   load_val;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rd_masked;
  logic [LANES-1:0]   be_q, lane_n;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid & req_ready;
  assign sel       = (phase == PH_STROBE);

  psram_phase_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  psram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC),
    .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC), .TMR_W(TMR_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(accept), .is_write(wr_q),
    .expired(expired), .phase(phase), .load(load), .load_val(load_val)
  );

  psram_lane_ctrl #(.DATA_W(DATA_W)) u_lane (
    .sel(sel), .be(be_q), .rd_bus(mem_dq_in),
    .lane_n(lane_n), .rd_masked(rd_masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (sel && expired && !wr_q) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_masked;
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  assign mem_ce_n   = ~sel;
  assign mem_ce2    = sel;
  assign mem_oe_n   = ~(sel & ~wr_q);
  assign mem_we_n   = ~(sel & wr_q);
  assign mem_lb_n   = lane_n[0];
  assign mem_ub_n   = lane_n[LANES-1];
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_q & ((phase == PH_SETUP) | sel | (phase == PH_HOLD));
endmodule

// File: rtl/psram_seq_chk.sv
module psram_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_select_only_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);

  assert_addr_settled_at_select_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> $stable(mem_addr));

  assert_addr_stable_selected_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_oe_we_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  assert_we_inside_select_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce2));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  assert_bus_released_early_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_data_held_after_we_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_standby_when_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (!mem_ce2 && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n));
endmodule

bind psram_seq psram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
  .mem_lb_n(mem_lb_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_psram_seq.sv
module sim_psram_seq;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2, RA = 4, WA = 3, H = 1, RC = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_seq #(.SETUP_CYC(S), .RD_CYC(RA), .WR_CYC(WA), .HOLD_CYC(H), .RECOV_CYC(RC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // Device model: async pseudo-static RAM
  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];
  bit wr_prev = 0;
  logic [15:0] wr_buf;
  logic [1:0] wr_lanes;
  int wr_addr;

  function automatic logic [15:0] rd_dev(int a);
    return dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_ref(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  always_comb begin
    logic [15:0] w;
    w = rd_dev(int'(mem_addr));
    if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n)
      mem_dq_in = {(!mem_ub_n ? w[15:8] : 8'hA5), (!mem_lb_n ? w[7:0] : 8'hA5)};
    else
      mem_dq_in = 16'h5A5A;
  end

  always @(negedge clk) begin
    bit act;
    act = !mem_ce_n && mem_ce2 && !mem_we_n && (!mem_ub_n || !mem_lb_n);
    if (act) begin
      wr_buf = mem_dq_out; wr_lanes = ~{mem_ub_n, mem_lb_n}; wr_addr = int'(mem_addr);
    end else if (wr_prev && mem_dq_oe && mem_dq_out == wr_buf) begin
      logic [15:0] w;
      w = rd_dev(wr_addr);
      if (wr_lanes[0]) w[7:0]  = wr_buf[7:0];
      if (wr_lanes[1]) w[15:8] = wr_buf[15:8];
      dev_mem[wr_addr] = w;
    end
    wr_prev = act;
  end

  // Reference model: phase count since acceptance
  bit busy = 0;
  int k = 0, tot = 0;
  bit t_wr;
  logic [18:0] t_addr;
  logic [15:0] t_wdata, t_rsp;
  logic [1:0] t_be;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      busy <= 0; k <= 0;
    end else if (busy) begin
      if (k == tot - 1) busy <= 0;
      else k <= k + 1;
    end else if (req_valid) begin
      logic [15:0] w;
      busy <= 1; k <= 0;
      t_wr <= req_write; t_addr <= req_addr; t_wdata <= req_wdata; t_be <= req_be;
      tot <= S + (req_write ? WA : RA) + H + RC;
      w = rd_ref(int'(req_addr));
      t_rsp <= {(req_be[1] ? w[15:8] : 8'h00), (req_be[0] ? w[7:0] : 8'h00)};
      if (req_write) begin
        if (req_be[0]) w[7:0]  = req_wdata[7:0];
        if (req_be[1]) w[15:8] = req_wdata[15:8];
        ref_mem[int'(req_addr)] = w;
      end
    end
  end

  // ctl vector: {ce_n, ce2, oe_n, we_n, ub_n, lb_n, dq_oe}
  always @(negedge clk) begin
    logic [6:0] act_v, exp_v;
    string tag;
    int acc;
    if (!rst && !done) begin
      act_v = {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe};
      acc = t_wr ? WA : RA;
      exp_v = 7'b1011110; tag = "R10";
      if (busy && k < S) begin
        exp_v = {6'b101111, t_wr}; tag = "R3";
        chk(mem_addr == t_addr, "R3 address", 32'(mem_addr), 32'(t_addr));
      end else if (busy && k < S + acc) begin
        exp_v = {1'b0, 1'b1, t_wr, !t_wr, !t_be[1], !t_be[0], t_wr};
        tag = t_wr ? "R5/R6" : "R4/R6";
        chk(mem_addr == t_addr, "R3 address while selected", 32'(mem_addr), 32'(t_addr));
      end else if (busy && k < S + acc + H) begin
        exp_v = {6'b101111, t_wr}; tag = "R8";
      end
      chk(act_v == exp_v, tag, 32'(act_v), 32'(exp_v));
      if (mem_dq_oe)
        chk(mem_dq_out == t_wdata, "R7 write data", 32'(mem_dq_out), 32'(t_wdata));
      chk(req_ready == !busy, "R2 ready", 32'(req_ready), 32'(!busy));
      chk(rsp_valid == (busy && !t_wr && k == S + RA), "R9 rsp_valid",
          32'(rsp_valid), 32'(busy && !t_wr && k == S + RA));
      if (rsp_valid && busy && !t_wr)
        chk(rsp_data == t_rsp, "R9 rsp_data", 32'(rsp_data), 32'(t_rsp));
    end
  end

  task automatic req(bit wr, logic [18:0] a, logic [15:0] d, logic [1:0] be);
    bit rdy;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      rdy = req_ready;
      @(negedge clk);
      if (rdy) break;
    end
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset/standby state
    chk({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready, rsp_valid}
        == 9'b101111010, "R1 reset state",
        32'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready, rsp_valid}),
        32'h17A);
    // R4/R5/R9: full-word write then read
    req(1, 19'h00010, 16'h1234, 2'b11); idle(12);
    req(0, 19'h00010, 16'h0000, 2'b11); idle(12);
    // R6: upper lane only write, full read
    req(1, 19'h00010, 16'hABCD, 2'b10); idle(3);
    req(0, 19'h00010, 16'h0000, 2'b11); idle(12);
    // R9: single-lane reads mask the other lane to zero
    req(0, 19'h00010, 16'h0000, 2'b01); idle(2);
    req(0, 19'h00010, 16'h0000, 2'b10); idle(12);
    // R6: write with no lanes leaves word unchanged
    req(1, 19'h00010, 16'hFFFF, 2'b00); idle(5);
    req(0, 19'h00010, 16'h0000, 2'b11); idle(12);
    // R3: top address
    req(1, 19'h7FFFF, 16'h5AA5, 2'b11);
    req(0, 19'h7FFFF, 16'h0000, 2'b11);
    // R7/R2: back-to-back with valid held; lower lane write then reads
    req(1, 19'h00020, 16'h00C3, 2'b01);
    req(0, 19'h00020, 16'h0000, 2'b11);
    req(1, 19'h00020, 16'h9900, 2'b10);
    req(0, 19'h00020, 16'h0000, 2'b11);
    req(0, 19'h00010, 16'h0000, 2'b11);
    idle(15);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    finish_run();
  end
endmodule